// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the arithmetic and logic core of a 32-bit data-processing stage. One operation runs per cycle. A 4-bit opcode selects it, two operands come in, and the pre-shifted operand arrives along with its shifter carry-out. The block returns the result together with two write strobes: one for the result and one for the condition flags. All arithmetic goes through a single carry-in adder. Subtraction uses the same adder, with one operand inverted and a carry-in, so the carry flag reads as "no borrow".

The block holds the current condition flags N, Z, C and V in a small register. A 4-bit condition field is checked against that register every cycle. When the condition fails, both strobes stay low and the flags keep their values. The test and compare opcodes only update the flags and never request a result write.

Top module: `alu_dp_core`

## Requirements
- R1: After reset, `flags_o` reads 0 (N, Z, C and V all clear).
- R2: Opcode encodings: 4 = ADD, 5 = ADC and 11 = CMN. ADD and CMN compute a+b, and ADC computes a+b+C. On a flag update, C is the carry out of bit 31. V is set when both adder inputs have the same sign and the sum has the other sign.
- R3: Opcode encodings: 2 = SUB, 3 = RSB, 6 = SBC, 7 = RSC and 10 = CMP. SUB and CMP compute a+~b+1, SBC computes a+~b+C, RSB computes b+~a+1 and RSC computes b+~a+C. C is set when no borrow occurs, and V follows the adder overflow rule.
- R4: Opcode encodings: 0 = AND, 1 = EOR, 8 = TST, 9 = TEQ, 12 = ORR, 13 = MOV, 14 = BIC and 15 = MVN. The results are a&b, a^b, a&b, a^b, a|b, b, a&~b and ~b. On a flag update, C takes `shift_carry_i` and V keeps its previous value.
- R5: After a flag update, N equals bit 31 of that cycle's result and Z is set exactly when that result is zero. This holds for every opcode.
- R6: Opcodes 8 to 11 (TST, TEQ, CMP, CMN) assert `flags_we_o` and never assert `result_we_o`. Every other opcode asserts `result_we_o`.
- R7: `cond_pass_o` follows the condition code: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 always.
- R8: Condition code 15 never passes. When the condition fails, both strobes are low and the flags are left unchanged.
- R9: The flags register updates on the clock edge only when `flags_we_o` is high, which happens when `set_flags_i` is high or the opcode is a test or compare. It is otherwise held. In `flags_o`, bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V.
- R10: `result_o` always carries the computed value for the current opcode, whether or not the condition passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Operation select |
| set_flags_i | input | 1 | Request a flag update for result-writing opcodes |
| cond_i | input | 4 | Condition field |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Second (shifted) operand |
| shift_carry_i | input | 1 | Carry-out of the operand shifter |
| result_o | output | 32 | Operation result |
| result_we_o | output | 1 | Result-write strobe |
| flags_we_o | output | 1 | Flag-write strobe |
| cond_pass_o | output | 1 | Condition evaluated true |
| flags_o | output | 4 | Current flags {N,Z,C,V} |

## Verification
The assertions check these rules on every cycle:
- Test and compare opcodes never raise the result strobe.
- Condition 15 never passes, and condition 14 always passes.
- A failed condition lowers both strobes.
- The flags hold whenever no flag write happens.
- A logical flag write leaves V alone.
- N and Z after any flag write match the previous cycle's result.

The exact arithmetic is shown only by the bench's sweep. The sweep covers every opcode against corner operand pairs, both carry sources and rotating condition codes. It compares the sums, the no-borrow carry, the overflow and the condition equations against a model built on wide signed and unsigned integers.

// File: rtl/alu_dp_pkg.sv
package alu_dp_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  // Opcodes that write flags only.
  function automatic logic op_is_test(input logic [3:0] op);
    return (op[3:2] == 2'b10);
  endfunction

  // Opcodes routed through the adder.
  function automatic logic op_is_arith(input logic [3:0] op);
    case (alu_op_e'(op))
      OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC, OP_CMP, OP_CMN: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic cond_holds(input logic [3:0] cc, input nzcv_t f);
    logic ge;
    ge = (f.n == f.v);
    case (cc)
      4'd0:  return f.z;
      4'd1:  return !f.z;
      4'd2:  return f.c;
      4'd3:  return !f.c;
      4'd4:  return f.n;
      4'd5:  return !f.n;
      4'd6:  return f.v;
      4'd7:  return !f.v;
      4'd8:  return f.c && !f.z;
      4'd9:  return !f.c || f.z;
      4'd10: return ge;
      4'd11: return !ge;
      4'd12: return !f.z && ge;
      4'd13: return f.z || !ge;
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/alu_dp_adder.sv
module alu_dp_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  logic [W:0] wide_sum;

  always_comb begin
    wide_sum = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
    sum_o    = wide_sum[W-1:0];
    cout_o   = wide_sum[W];
    ovf_o    = (x_i[W-1] == y_i[W-1]) && (wide_sum[W-1] != x_i[W-1]);
  end
endmodule

// File: rtl/alu_dp_logic.sv
module alu_dp_logic
  import alu_dp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    case (alu_op_e'(op_i))
      OP_AND, OP_TST: res_o = a_i & b_i;
      OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
      OP_ORR:         res_o = a_i | b_i;
      OP_MOV:         res_o = b_i;
      OP_BIC:         res_o = a_i & ~b_i;
      OP_MVN:         res_o = ~b_i;
      default:        res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_dp_cond.sv
module alu_dp_cond
  import alu_dp_pkg::*;
(
  input  logic [3:0] cond_i,
  input  nzcv_t      flags_i,
  output logic       pass_o
);
  assign pass_o = cond_holds(cond_i, flags_i);
endmodule

// File: rtl/alu_dp_core.sv
module alu_dp_core
  import alu_dp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op_i,
  input  logic         set_flags_i,
  input  logic [3:0]   cond_i,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  input  logic         shift_carry_i,
  output logic [W-1:0] result_o,
  output logic         result_we_o,
  output logic         flags_we_o,
  output logic         cond_pass_o,
  output logic [3:0]   flags_o
);
  localparam int MSB = W - 1;

  nzcv_t        flags_q;
  nzcv_t        flags_d;
  logic [W-1:0] add_x, add_y, add_sum, logic_res;
  logic         add_cin, add_cout, add_ovf;
  logic         is_arith_w, is_test_w, pass_w;

  assign is_arith_w = op_is_arith(op_i);
  assign is_test_w  = op_is_test(op_i);

  // Operand steering for the shared adder.
  always_comb begin
    add_x   = op_a_i;
    add_y   = op_b_i;
    add_cin = 1'b0;
    case (alu_op_e'(op_i))
      OP_ADD, OP_CMN: begin add_y = op_b_i;  add_cin = 1'b0;      end
      OP_ADC:         begin add_y = op_b_i;  add_cin = flags_q.c; end
      OP_SUB, OP_CMP: begin add_y = ~op_b_i; add_cin = 1'b1;      end
      OP_SBC:         begin add_y = ~op_b_i; add_cin = flags_q.c; end
      OP_RSB:         begin add_x = op_b_i; add_y = ~op_a_i; add_cin = 1'b1;      end
      OP_RSC:         begin add_x = op_b_i; add_y = ~op_a_i; add_cin = flags_q.c; end
      default: ;
    endcase
  end

  alu_dp_adder #(.W(W)) u_add (
    .x_i(add_x), .y_i(add_y), .cin_i(add_cin),
    .sum_o(add_sum), .cout_o(add_cout), .ovf_o(add_ovf)
  );

  alu_dp_logic #(.W(W)) u_log (
    .op_i(op_i), .a_i(op_a_i), .b_i(op_b_i), .res_o(logic_res)
  );

  alu_dp_cond u_cond (
    .cond_i(cond_i), .flags_i(flags_q), .pass_o(pass_w)
  );

  assign result_o    = is_arith_w ? add_sum : logic_res;
  assign cond_pass_o = pass_w;
  assign result_we_o = pass_w && !is_test_w;
  assign flags_we_o  = pass_w && (set_flags_i || is_test_w);

  always_comb begin
    flags_d.n = result_o[MSB];
    flags_d.z = (result_o == '0);
    flags_d.c = is_arith_w ? add_cout : shift_carry_i;
    flags_d.v = is_arith_w ? add_ovf  : flags_q.v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flags_q <= '0;
    else if (flags_we_o) flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/alu_dp_core_chk.sv
module alu_dp_core_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   op_i,
  input logic [3:0]   cond_i,
  input logic [W-1:0] result_o,
  input logic         result_we_o,
  input logic         flags_we_o,
  input logic         cond_pass_o,
  input logic [3:0]   flags_o
);
  logic test_op, logic_op;
  assign test_op  = (op_i >= 4'd8) && (op_i <= 4'd11);
  assign logic_op = (op_i == 4'd0) || (op_i == 4'd1) || (op_i == 4'd8) || (op_i == 4'd9)
                    || (op_i >= 4'd12);

  assert_test_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    test_op |-> !result_we_o);

  assert_never_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i == 4'hF) |-> !cond_pass_o);

  assert_always_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i == 4'hE) |-> cond_pass_o);

  assert_fail_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_pass_o |-> (!result_we_o && !flags_we_o));

  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_we_o |=> $stable(flags_o));

  assert_logic_keeps_v_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_we_o && logic_op) |=> (flags_o[0] == $past(flags_o[0])));

  assert_nz_from_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we_o |=> (flags_o[3] == $past(result_o[W-1]) &&
                    flags_o[2] == ($past(result_o) == '0)));
endmodule

bind alu_dp_core alu_dp_core_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .cond_i(cond_i),
  .result_o(result_o), .result_we_o(result_we_o), .flags_we_o(flags_we_o),
  .cond_pass_o(cond_pass_o), .flags_o(flags_o)
);

// File: tb/sim_alu_dp_core.sv
module sim_alu_dp_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_i = '0;
  logic        set_flags_i = 1'b0;
  logic [3:0]  cond_i = 4'hE;
  logic [31:0] op_a_i = '0, op_b_i = '0;
  logic        shift_carry_i = 1'b0;
  logic [31:0] result_o;
  logic        result_we_o, flags_we_o, cond_pass_o;
  logic [3:0]  flags_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_dp_core u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .set_flags_i(set_flags_i), .cond_i(cond_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .shift_carry_i(shift_carry_i),
    .result_o(result_o), .result_we_o(result_we_o), .flags_we_o(flags_we_o),
    .cond_pass_o(cond_pass_o), .flags_o(flags_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit model_cond(input logic [3:0] cc, input logic [3:0] f);
    bit n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      0: return z;            1: return !z;
      2: return c;            3: return !c;
      4: return n;            5: return !n;
      6: return v;            7: return !v;
      8: return c & ~z;       9: return ~c | z;
      10: return n ~^ v;      11: return n ^ v;
      12: return ~z & (n ~^ v);
      13: return z | (n ^ v);
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] pick(input int i);
    case (i)
      0: return 32'h0000_0000; 1: return 32'h0000_0001;
      2: return 32'h7FFF_FFFF; 3: return 32'h8000_0000;
      4: return 32'hFFFF_FFFF; 5: return 32'h1234_5678;
      6: return 32'hFFFF_FFFE; default: return 32'h8000_0001;
    endcase
  endfunction

  logic [3:0] mflags;

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt;
    cnt = 0;
    mflags = 4'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 reset flags", flags_o, 4'h0);

    for (int op = 0; op < 16; op++) begin       // R10 encodings per R2 R3 R4
      for (int ia = 0; ia < 8; ia++) begin
        for (int ib = 0; ib < 8; ib++) begin
          for (int k = 0; k < 4; k++) begin
            logic [31:0] a, b, er;
            longint      ua, ub, sa, sb, s, sr;
            bit          cin, ec, ev, ispass, istest, isarith, eflags_we;
            string       tag;
            a = pick(ia); b = pick(ib);
            cin = mflags[1];
            isarith = 1'b1; ec = 0; ev = mflags[0]; er = '0;
            case (op)
              4, 11: begin ua = a; ub = b; sa = $signed(a); sb = $signed(b); cin = 0; tag = "R2"; end
              5:     begin ua = a; ub = b; sa = $signed(a); sb = $signed(b); tag = "R2"; end
              2, 10: begin ua = a; ub = b; sa = $signed(a); sb = $signed(b); cin = 1; tag = "R3"; end
              6:     begin ua = a; ub = b; sa = $signed(a); sb = $signed(b); tag = "R3"; end
              3:     begin ua = b; ub = a; sa = $signed(b); sb = $signed(a); cin = 1; tag = "R3"; end
              7:     begin ua = b; ub = a; sa = $signed(b); sb = $signed(a); tag = "R3"; end
              default: begin isarith = 0; ua = 0; ub = 0; sa = 0; sb = 0; tag = "R4"; end
            endcase
            if (isarith && tag == "R2") begin
              s  = ua + ub + longint'(cin);
              er = s[31:0];
              ec = (s >= 64'h1_0000_0000);
              sr = sa + sb + longint'(cin);
              ev = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
            end else if (isarith) begin
              s  = ua - ub - longint'(!cin);
              er = s[31:0];
              ec = (ua >= ub + longint'(!cin));
              sr = sa - sb - longint'(!cin);
              ev = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
            end else begin
              case (op)
                0, 8: er = a & b;   1, 9: er = a ^ b;
                12: er = a | b;     13: er = b;
                14: er = a & ~b;    default: er = ~b;
              endcase
              ec = (k >> 1) & 1;
              ev = mflags[0];
            end
            istest = (op >= 8 && op <= 11);

            @(negedge clk);
            op_i = 4'(op); op_a_i = a; op_b_i = b;
            set_flags_i = k[0]; shift_carry_i = k[1];
            cond_i = 4'((cnt * 5 + cnt / 16) % 16);
            cnt++;
            #1;
            ispass = model_cond(cond_i, mflags);
            eflags_we = ispass && (set_flags_i || istest);
            chk($sformatf("%s R10 result op=%0d", tag, op), result_o, er);
            chk(cond_i == 15 ? "R8 cond pass" : "R7 cond pass", cond_pass_o, ispass);
            chk(ispass ? "R6 result strobe" : "R8 result strobe", result_we_o, ispass && !istest);
            chk(ispass ? "R6 flag strobe" : "R8 flag strobe", flags_we_o, eflags_we);
            @(posedge clk);
            #1;
            if (eflags_we) begin
              chk("R5 N Z", flags_o[3:2], {er[31], er == 0});
              chk({tag, " C V"}, flags_o[1:0], {ec, ev});
              mflags = {er[31], er == 0, ec, ev};
            end else begin
              chk("R9 flags held", flags_o, mflags);
            end
          end
        end
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule